// File: doc/BRIEF.md
# Serial Port Interrupt Identity Encoder

This block gathers the interrupt conditions of a serial port and reports the single most urgent one as a fixed 4-bit identity code. Software reads that code from an identity register. A combined interrupt line follows the code. The surrounding port logic supplies three kinds of input: the interrupt enable bits, raw event strobes and the receive trigger level, and the strobes of the register reads and writes that have side effects. Each source keeps its own pending flag and has its own clear rule. A source is cleared by the register access that services it, and not by a generic acknowledge.

The code comes combinationally from the registered pending flags after enable masking. Received data and character timeout share one enable. Busy detect cannot be masked. A per-source clear pulse marks the cycle in which each flag is being cleared, so that the neighbouring status logic can follow. In FIFO mode the received-data flag follows the trigger-level input one cycle late. In non-FIFO mode it is set by a character arrival and cleared by a read of the receive buffer.

Top module: `uart_iid_top`

## Requirements
- R1: Under reset and in the first cycle after it, `id_o` is 4'b0001, `irq_o` is low and `clr_o` is all zero.
- R2: Codes are: line error 4'b0110, received data 4'b0100, character timeout 4'b1100, transmit empty 4'b0010, busy 4'b0111, modem 4'b0000, nothing pending 4'b0001. When several sources are active, the code reported follows this order, highest first: line error, received data, timeout, transmit empty, busy, modem.
- R3: `en_i[0]` masks both received data and timeout, `en_i[1]` masks transmit empty, `en_i[2]` masks line error and `en_i[3]` masks modem. Busy has no mask. A masked source stays pending and is reported once it is enabled.
- R4: A `line_err_i` strobe sets the line-error flag. A `ln_stat_rd_i` strobe clears it.
- R5: With `fifo_en_i` low, a `rx_char_i` strobe sets the received-data flag and a `rx_buf_rd_i` strobe clears it.
- R6: With `fifo_en_i` high, the received-data flag takes the value that `rx_at_trig_i` had at the previous edge.
- R7: A `rx_timeout_i` strobe sets the timeout flag only while `fifo_en_i` is high. A `rx_buf_rd_i` strobe clears it, and so does `fifo_en_i` being low.
- R8: The transmit-empty flag is set by `tx_empty_i`. It is cleared by `tx_hold_wr_i`, or by `id_rd_i` while `id_o` is 4'b0010. A read of the identity register while another code is shown leaves it pending.
- R9: The busy flag is set by `busy_det_i` and cleared by `stat_rd_i`. The modem flag is set by `modem_chg_i` and cleared by `modem_rd_i`.
- R10: When a set strobe and a clear condition for the same source fall in one cycle, the flag stays pending and no clear pulse is given.
- R11: `irq_o` is high exactly when `id_o` differs from 4'b0001.
- R12: `clr_o` bit i is high in the cycle before flag i drops from 1 to 0. The bit order is 0 line error, 1 received data, 2 timeout, 3 transmit empty, 4 busy, 5 modem.
- R13: `id_o[3]` is never set in the cycle after an edge at which `fifo_en_i` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 4 | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFO mode selected |
| line_err_i | input | 1 | Overrun, parity, framing or break strobe |
| rx_char_i | input | 1 | Character received strobe (non-FIFO mode) |
| rx_at_trig_i | input | 1 | Receive FIFO at or above trigger level |
| rx_timeout_i | input | 1 | Character timeout strobe |
| tx_empty_i | input | 1 | Transmit holding register became empty |
| busy_det_i | input | 1 | Busy detect strobe |
| modem_chg_i | input | 1 | Modem status change strobe |
| ln_stat_rd_i | input | 1 | Line status register read |
| rx_buf_rd_i | input | 1 | Receive buffer read |
| id_rd_i | input | 1 | Identity register read |
| tx_hold_wr_i | input | 1 | Transmit holding register write |
| stat_rd_i | input | 1 | Port status register read |
| modem_rd_i | input | 1 | Modem status register read |
| id_o | output | 4 | Identity code of the highest pending source |
| irq_o | output | 1 | Combined interrupt |
| clr_o | output | 6 | Per-source clear pulses |

## Verification
Setting a source and clearing it can land in the same cycle: a new line error together with a line status read, a new transmit-empty event together with a holding write, and a new transmit-empty event together with an identity read while 4'b0010 is shown. The bench drives each of these pairs in one cycle. It then expects the code to remain and the matching clear pulse to stay low. A second kind of coincidence is two sources pending at once, as with timeout and received data in FIFO mode. There the bench checks that the code of the higher-ranked source is shown, and that clearing one of the two leaves the other reported.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;
   localparam int SRC_N = 6;
   localparam int CODE_W = 4;

   localparam int S_LS   = 0;
   localparam int S_RX   = 1;
   localparam int S_TMO  = 2;
   localparam int S_TX   = 3;
   localparam int S_BUSY = 4;
   localparam int S_MS   = 5;

   localparam logic [CODE_W-1:0] ID_LS   = 4'b0110;
   localparam logic [CODE_W-1:0] ID_RX   = 4'b0100;
   localparam logic [CODE_W-1:0] ID_TMO  = 4'b1100;
   localparam logic [CODE_W-1:0] ID_TX   = 4'b0010;
   localparam logic [CODE_W-1:0] ID_BUSY = 4'b0111;
   localparam logic [CODE_W-1:0] ID_MS   = 4'b0000;
   localparam logic [CODE_W-1:0] ID_NONE = 4'b0001;
endpackage

// File: rtl/uart_iid_flag.sv
module uart_iid_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o,
   output logic clr_pulse_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i | (q & ~clr_i);
   end

   assign q_o         = q;
   assign clr_pulse_o = q & clr_i & ~set_i;
endmodule

// File: rtl/uart_iid_rx.sv
module uart_iid_rx (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_en_i,
   input  logic char_i,
   input  logic at_trig_i,
   input  logic buf_rd_i,
   output logic q_o,
   output logic clr_pulse_o
);
   logic q;
   logic nxt;

   always_comb begin
      if (fifo_en_i) nxt = at_trig_i;
      else           nxt = char_i | (q & ~buf_rd_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end

   assign q_o         = q;
   assign clr_pulse_o = q & ~nxt;
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
   import uart_iid_pkg::*;
(
   input  logic [SRC_N-1:0]  act_i,
   output logic [CODE_W-1:0] id_o
);
   always_comb begin
      if      (act_i[S_LS])   id_o = ID_LS;
      else if (act_i[S_RX])   id_o = ID_RX;
      else if (act_i[S_TMO])  id_o = ID_TMO;
      else if (act_i[S_TX])   id_o = ID_TX;
      else if (act_i[S_BUSY]) id_o = ID_BUSY;
      else if (act_i[S_MS])   id_o = ID_MS;
      else                    id_o = ID_NONE;
   end
endmodule

// File: rtl/uart_iid_top.sv
module uart_iid_top
   import uart_iid_pkg::*;
#(
   parameter int EN_W           = 4,
   parameter int ID_W           = 4,
   parameter bit TX_ID_READ_CLR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EN_W-1:0] en_i,
   input  logic            fifo_en_i,
   input  logic            line_err_i,
   input  logic            rx_char_i,
   input  logic            rx_at_trig_i,
   input  logic            rx_timeout_i,
   input  logic            tx_empty_i,
   input  logic            busy_det_i,
   input  logic            modem_chg_i,
   input  logic            ln_stat_rd_i,
   input  logic            rx_buf_rd_i,
   input  logic            id_rd_i,
   input  logic            tx_hold_wr_i,
   input  logic            stat_rd_i,
   input  logic            modem_rd_i,
   output logic [ID_W-1:0] id_o,
   output logic            irq_o,
   output logic [SRC_N-1:0] clr_o
);
   generate
      if (EN_W < 4) begin : g_bad_en
         $error("EN_W must hold at least four enable bits");
      end
      if (ID_W != CODE_W) begin : g_bad_id
         $error("ID_W must equal the identity code width");
      end
   endgenerate

   logic [SRC_N-1:0] set_v, clr_v, pend, mask, act;
   logic             tx_id_clr;

   generate
      if (TX_ID_READ_CLR) begin : g_tx_idclr
         assign tx_id_clr = id_rd_i & (id_o == ID_TX);
      end else begin : g_tx_noidclr
         assign tx_id_clr = 1'b0;
      end
   endgenerate

   assign set_v[S_LS]   = line_err_i;
   assign clr_v[S_LS]   = ln_stat_rd_i;
   assign set_v[S_RX]   = rx_char_i;
   assign clr_v[S_RX]   = rx_buf_rd_i;
   assign set_v[S_TMO]  = rx_timeout_i & fifo_en_i;
   assign clr_v[S_TMO]  = rx_buf_rd_i | ~fifo_en_i;
   assign set_v[S_TX]   = tx_empty_i;
   assign clr_v[S_TX]   = tx_hold_wr_i | tx_id_clr;
   assign set_v[S_BUSY] = busy_det_i;
   assign clr_v[S_BUSY] = stat_rd_i;
   assign set_v[S_MS]   = modem_chg_i;
   assign clr_v[S_MS]   = modem_rd_i;

   genvar gi;
   generate
      for (gi = 0; gi < SRC_N; gi++) begin : g_src
         if (gi == S_RX) begin : g_rx
            uart_iid_rx u_rx (
               .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i),
               .char_i(set_v[gi]), .at_trig_i(rx_at_trig_i),
               .buf_rd_i(clr_v[gi]), .q_o(pend[gi]), .clr_pulse_o(clr_o[gi])
            );
         end else begin : g_flag
            uart_iid_flag u_flag (
               .clk(clk), .rst_n(rst_n), .set_i(set_v[gi]), .clr_i(clr_v[gi]),
               .q_o(pend[gi]), .clr_pulse_o(clr_o[gi])
            );
         end
      end
   endgenerate

   assign mask[S_LS]   = en_i[2];
   assign mask[S_RX]   = en_i[0];
   assign mask[S_TMO]  = en_i[0];
   assign mask[S_TX]   = en_i[1];
   assign mask[S_BUSY] = 1'b1;
   assign mask[S_MS]   = en_i[3];
   assign act          = pend & mask;

   uart_iid_prio u_prio (.act_i(act), .id_o(id_o));

   assign irq_o = (id_o != ID_NONE);

   logic unused_en;
   assign unused_en = ^en_i;
endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] en_i,
   input logic       fifo_en_i,
   input logic       line_err_i,
   input logic       rx_timeout_i,
   input logic       tx_empty_i,
   input logic       ln_stat_rd_i,
   input logic       rx_buf_rd_i,
   input logic       tx_hold_wr_i,
   input logic [3:0] id_o,
   input logic       irq_o
);
   assert_line_err_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      line_err_i |=> (!en_i[2] || id_o == 4'b0110));

   assert_line_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      line_err_i |=> (!en_i[2] || irq_o));

   assert_ls_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ln_stat_rd_i && !line_err_i) |=> (id_o != 4'b0110));

   assert_tmo_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_buf_rd_i && !rx_timeout_i) |=> (id_o != 4'b1100));

   assert_thr_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_hold_wr_i && !tx_empty_i) |=> (id_o != 4'b0010));

   assert_bit3_fifo_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en_i |=> !id_o[3]);
endmodule

bind uart_iid_top uart_iid_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i[3:0]), .fifo_en_i(fifo_en_i),
   .line_err_i(line_err_i), .rx_timeout_i(rx_timeout_i), .tx_empty_i(tx_empty_i),
   .ln_stat_rd_i(ln_stat_rd_i), .rx_buf_rd_i(rx_buf_rd_i),
   .tx_hold_wr_i(tx_hold_wr_i), .id_o(id_o), .irq_o(irq_o)
);

// File: tb/uart_iid_top_bench.sv
module uart_iid_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] en_i = '0;
   logic       fifo_en_i = 1'b0;
   logic       line_err_i = 0, rx_char_i = 0, rx_at_trig_i = 0, rx_timeout_i = 0;
   logic       tx_empty_i = 0, busy_det_i = 0, modem_chg_i = 0;
   logic       ln_stat_rd_i = 0, rx_buf_rd_i = 0, id_rd_i = 0, tx_hold_wr_i = 0;
   logic       stat_rd_i = 0, modem_rd_i = 0;
   logic [3:0] id_o;
   logic       irq_o;
   logic [5:0] clr_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   uart_iid_top u_uart_iid_top (.*);

   // ev = {line_err, rx_char, rx_trig, timeout, tx_empty, busy, modem}
   // rd = {ln_stat_rd, rx_buf_rd, id_rd, tx_hold_wr, stat_rd, modem_rd}
   // eclr = clr_o bits {modem, busy, tx, timeout, rx, line}
   typedef struct packed {
      logic [3:0] en;
      logic       fifo;
      logic [6:0] ev;
      logic [5:0] rd;
      logic [5:0] eclr;
      logic [3:0] eid;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t TBL [NV] = '{
      '{4'hF,1'b0,7'b0000001,6'b000000,6'b000000,4'b0000}, // modem lowest R2
      '{4'hF,1'b0,7'b0000010,6'b000000,6'b000000,4'b0111}, // busy over modem
      '{4'hF,1'b0,7'b0000100,6'b000000,6'b000000,4'b0010}, // tx over busy
      '{4'hF,1'b0,7'b0100000,6'b000000,6'b000000,4'b0100}, // rx non-FIFO R5
      '{4'hF,1'b0,7'b1000000,6'b000000,6'b000000,4'b0110}, // line R4
      '{4'hF,1'b0,7'b0000000,6'b100000,6'b000001,4'b0100}, // ls read
      '{4'hF,1'b0,7'b0000000,6'b001000,6'b000000,4'b0100}, // id read not tx R8
      '{4'hF,1'b0,7'b0000000,6'b010000,6'b000010,4'b0010}, // rbr read R5
      '{4'hF,1'b0,7'b0000000,6'b001000,6'b001000,4'b0111}, // id read tx R8
      '{4'hF,1'b0,7'b0000000,6'b000010,6'b010000,4'b0000}, // stat read R9
      '{4'hF,1'b0,7'b0000000,6'b000001,6'b100000,4'b0001}, // modem read R9
      '{4'hF,1'b0,7'b1000000,6'b100000,6'b000000,4'b0110}, // set wins R10
      '{4'hF,1'b0,7'b0000000,6'b100000,6'b000001,4'b0001},
      '{4'hF,1'b1,7'b0001000,6'b000000,6'b000000,4'b1100}, // timeout R7
      '{4'hF,1'b1,7'b0010000,6'b000000,6'b000000,4'b0100}, // FIFO rx R6
      '{4'hF,1'b1,7'b0010000,6'b010000,6'b000100,4'b0100}, // rbr clears tmo only
      '{4'hF,1'b1,7'b0000000,6'b000000,6'b000010,4'b0001}, // level drop R6
      '{4'h0,1'b1,7'b0001101,6'b000000,6'b000000,4'b0001}, // all masked R3
      '{4'h2,1'b1,7'b0000000,6'b000000,6'b000000,4'b0010},
      '{4'h1,1'b1,7'b0000000,6'b000000,6'b000000,4'b1100},
      '{4'h8,1'b1,7'b0000000,6'b000000,6'b000000,4'b0000},
      '{4'hF,1'b0,7'b0000000,6'b000000,6'b000100,4'b0010}, // FIFO off clears tmo R7
      '{4'hF,1'b0,7'b0000000,6'b000100,6'b001000,4'b0000}, // thr write R8
      '{4'hF,1'b0,7'b0000100,6'b000100,6'b000000,4'b0010}, // set wins R10
      '{4'hF,1'b0,7'b0000100,6'b001000,6'b000000,4'b0010}, // set wins R10
      '{4'hF,1'b0,7'b0000000,6'b000100,6'b001000,4'b0000},
      '{4'hF,1'b0,7'b0000000,6'b000001,6'b100000,4'b0001},
      '{4'hF,1'b0,7'b0001000,6'b000000,6'b000000,4'b0001}, // timeout ignored R13
      '{4'h0,1'b0,7'b0000010,6'b000000,6'b000000,4'b0111}, // busy unmasked R3
      '{4'h0,1'b0,7'b0000000,6'b000010,6'b010000,4'b0001}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      en_i = v.en; fifo_en_i = v.fifo;
      {line_err_i, rx_char_i, rx_at_trig_i, rx_timeout_i, tx_empty_i, busy_det_i, modem_chg_i} = v.ev;
      {ln_stat_rd_i, rx_buf_rd_i, id_rd_i, tx_hold_wr_i, stat_rd_i, modem_rd_i} = v.rd;
   endtask

   initial begin
      #200000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      vec_t z;
      z = '0;
      repeat (2) @(negedge clk);
      check("R1 id", {4'b0, id_o}, 8'h01);
      check("R1 irq", {7'b0, irq_o}, 8'h00);
      check("R1 clr", {2'b0, clr_o}, 8'h00);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 id after", {4'b0, id_o}, 8'h01);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(TBL[i]);
         #1;
         check("R12 clr", {2'b0, clr_o}, {2'b0, TBL[i].eclr});
         @(posedge clk); #1;
         check("R2 id", {4'b0, id_o}, {4'b0, TBL[i].eid});
         check("R11 irq", {7'b0, irq_o}, {7'b0, (TBL[i].eid != 4'b0001)});
      end

      // Reset with sources pending: everything returns to idle (R1)
      @(negedge clk);
      apply(z);
      en_i = 4'hF; line_err_i = 1; modem_chg_i = 1;
      @(negedge clk);
      line_err_i = 0; modem_chg_i = 0;
      check("R4 pre-reset", {4'b0, id_o}, 8'h06);
      rst_n = 1'b0;
      #1;
      check("R1 reset id", {4'b0, id_o}, 8'h01);
      check("R1 reset irq", {7'b0, irq_o}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R9 modem cleared by reset", {4'b0, id_o}, 8'h01);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule